// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of an eight-channel, 10-bit successive-approximation converter. Software reaches it over a simple byte-wide bus that has a write strobe and an asynchronous read mux. Through that bus it programs two control registers and reads per-channel results. The block divides the system clock into a conversion tick and drives a trial code towards an external DAC. It also drives a channel select towards the analog multiplexer. On each tick it takes one decision from a single-bit comparator that reports whether the sampled input is at or above the trial code.

Four conversion modes are available. The single-channel modes convert either once or continuously. The sweep modes scan channel 0 through 7 either once or continuously. Each result goes to that channel's byte pair, laid out as a 10-bit value or as an 8-bit value, whichever width is selected at that moment. A control bit disconnects the reference ladder to save current. After the ladder is reconnected, a programmable settle time of system clocks must pass before a conversion can start. A one-cycle interrupt pulse marks the end of a single conversion and the end of each complete sweep.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, control register 0 (address 0x1E) reads 0x00, control register 1 (address 0x1F) reads 0x20, every result byte reads 0x00, and `ladder_en` and `irq` are low.
- R2: Control register 0 layout: bit 7 tick rate, bit 6 start/busy, bit 5 reads 0, bits 4:3 mode, bits 2:0 channel. Control register 1 layout: bit 5 ladder off, bit 3 ten-bit width, all other bits read 0. Channel n's result bytes sit at 0x20+2n (low byte) and 0x21+2n (high byte).
- R3: With bit 7 of control register 0 at 0, a tick occurs every 4 system clocks. With it at 1, a tick occurs every 2 system clocks. A conversion takes 10 ticks, so `irq` rises 40 or 20 cycles after the clock edge that accepts a one-shot start.
- R4: Bits are tested MSB first, one per tick. The first trial code after a start is 0x200. A bit is kept when `cmp_in` is high, so for an ideal comparator the result equals the input code.
- R5: With bit 3 of control register 1 at 1, the low byte holds result bits 7:0. The high byte holds result bits 9:8 in its bits 1:0 and reads 0 in bits 7:2.
- R6: With bit 3 of control register 1 at 0, the low byte holds result bits 9:2 and the high byte reads 0x00.
- R7: Mode 00 (one-shot) converts the channel in bits 2:0 once, clears bit 6 and pulses `irq` at the end.
- R8: Mode 01 (repeat) keeps converting the selected channel and refreshing its result. Bit 6 stays set and `irq` is never raised.
- R9: Mode 10 (single sweep) converts channels 0 through 7 in order. It then clears bit 6 and pulses `irq` exactly once.
- R10: Mode 11 (repeat sweep) pulses `irq` after each pass over channels 0 through 7 and restarts at channel 0.
- R11: `ladder_en` is the inverse of bit 5 of control register 1. A start request (bit 6 written 1) is ignored while the ladder is off, or for SETTLE_CYC system clocks after bit 5 goes from 1 to 0. Setting bit 5 during a conversion stops it and clears bit 6.
- R12: `irq` is never high for two consecutive cycles.
- R13: Writing bit 6 to 0 during a conversion stops it. No further result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one byte per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code for the reference DAC |
| chan_sel | output | 3 | Analog channel being converted |
| ladder_en | output | 1 | Reference ladder connect |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench models an ideal comparator against a per-channel input code. The stored result must therefore reproduce that code exactly. Extreme codes (0x3FF, 0x003) and codes with alternating bits (0x2A5, 0x155) separate a correct MSB-first decision from a shifted, inverted or stuck bit. The same codes read in 10-bit and in 8-bit width separate the two byte layouts. A sweep over eight distinct codes shows that channel stepping and result addressing agree. Changing an input during repeat mode, and again after a stop, separates continuous refresh from a single conversion and from one that keeps running after the stop.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int RES_W = 10;
    localparam int CHF_W = 3;

    localparam logic [7:0] CTRL0_ADDR = 8'h1E;
    localparam logic [7:0] CTRL1_ADDR = 8'h1F;
    localparam logic [7:0] RES_BASE   = 8'h20;

    typedef enum logic [1:0] {
        MODE_ONCE      = 2'b00,
        MODE_REPEAT    = 2'b01,
        MODE_SWEEP     = 2'b10,
        MODE_REP_SWEEP = 2'b11
    } adc_mode_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic half_rate,
    output logic tick
);
    logic [1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = clear ? 2'd0 : cnt_q + 2'd1;
        tick  = half_rate ? cnt_q[0] : (cnt_q == 2'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         tick,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic         done,
    output logic [W-1:0] result
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] acc;
        logic [W-1:0] trial;
    } core_t;

    core_t q, d;

    assign dac_code = q.acc | q.trial;
    assign done     = q.run && tick && q.trial[0];
    assign result   = cmp_in ? (q.acc | q.trial) : q.acc;

    always_comb begin
        d = q;
        if (abort) begin
            d = '0;
        end else if (start) begin
            d.run   = 1'b1;
            d.acc   = '0;
            d.trial = {1'b1, {(W-1){1'b0}}};
        end else if (q.run && tick) begin
            if (q.trial[0]) begin
                d = '0;
            end else begin
                d.acc   = result;
                d.trial = q.trial >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
    parameter int NUM_CH = 8,
    parameter int W      = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [W-1:0]    wr_data,
    input  logic            ten_bit,
    input  logic [CH_W-1:0] rd_ch,
    input  logic            rd_high,
    output logic [7:0]      rd_byte
);
    localparam int HI_W = W - 8;

    logic [7:0]      low_arr  [NUM_CH];
    logic [HI_W-1:0] high_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [7:0]      low_q,  low_d;
        logic [HI_W-1:0] high_q, high_d;

        always_comb begin
            low_d  = low_q;
            high_d = high_q;
            if (wr_en && (wr_ch == CH_W'(g))) begin
                if (ten_bit) begin
                    low_d  = wr_data[7:0];
                    high_d = wr_data[W-1:8];
                end else begin
                    low_d  = wr_data[W-1:W-8];
                    high_d = '0;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                low_q  <= '0;
                high_q <= '0;
            end else begin
                low_q  <= low_d;
                high_q <= high_d;
            end
        end

        assign low_arr[g]  = low_q;
        assign high_arr[g] = high_q;
    end

    assign rd_byte = rd_high ? {{(8-HI_W){1'b0}}, high_arr[rd_ch]} : low_arr[rd_ch];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [2:0]       chan_sel,
    output logic             ladder_en,
    output logic             irq
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic                clk_half;
        logic                busy;
        adc_mode_e           mode;
        logic [CHF_W-1:0]    chan;
        logic                ten_bit;
        logic                ladder_off;
        logic [SETTLE_W-1:0] settle;
        logic [CH_W-1:0]     cur_ch;
        logic                irq;
    } ctl_t;

    ctl_t q, d;

    logic             tick, core_start, core_abort, core_done;
    logic [RES_W-1:0] core_result;
    logic             store_en;
    logic [CH_W-1:0]  store_ch;
    logic [7:0]       rd_off, bank_byte;
    logic             rd_hit;
    logic             wr_c0, wr_c1, start_ok;
    logic             busy_w;
    logic [1:0]       mode_w;

    assign wr_c0    = bus_wr && (bus_addr == CTRL0_ADDR);
    assign wr_c1    = bus_wr && (bus_addr == CTRL1_ADDR);
    assign start_ok = !q.ladder_off && (q.settle == '0);
    assign rd_off   = bus_addr - RES_BASE;
    assign rd_hit   = (bus_addr >= RES_BASE) && (rd_off < 8'(2 * NUM_CH));

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        core_start = 1'b0;
        core_abort = 1'b0;
        store_en   = 1'b0;
        store_ch   = q.cur_ch;

        if (q.settle != '0) d.settle = q.settle - SETTLE_W'(1);

        if (core_done) begin
            store_en = 1'b1;
            unique case (q.mode)
                MODE_ONCE: begin
                    d.busy = 1'b0;
                    d.irq  = 1'b1;
                end
                MODE_REPEAT: begin
                    core_start = 1'b1;
                end
                MODE_SWEEP: begin
                    if (q.cur_ch == LAST_CH) begin
                        d.busy = 1'b0;
                        d.irq  = 1'b1;
                    end else begin
                        d.cur_ch   = q.cur_ch + CH_W'(1);
                        core_start = 1'b1;
                    end
                end
                MODE_REP_SWEEP: begin
                    core_start = 1'b1;
                    if (q.cur_ch == LAST_CH) begin
                        d.cur_ch = '0;
                        d.irq    = 1'b1;
                    end else begin
                        d.cur_ch = q.cur_ch + CH_W'(1);
                    end
                end
                default: ;
            endcase
        end

        if (wr_c1) begin
            d.ten_bit    = bus_wdata[3];
            d.ladder_off = bus_wdata[5];
            if (!bus_wdata[5] && q.ladder_off)
                d.settle = SETTLE_W'(SETTLE_CYC);
            if (bus_wdata[5] && q.busy) begin
                core_abort = 1'b1;
                d.busy     = 1'b0;
            end
        end

        if (wr_c0) begin
            d.clk_half = bus_wdata[7];
            d.mode     = adc_mode_e'(bus_wdata[4:3]);
            d.chan     = bus_wdata[2:0];
            if (!q.busy && bus_wdata[6] && start_ok) begin
                d.busy     = 1'b1;
                core_start = 1'b1;
                if (bus_wdata[4]) d.cur_ch = '0;
                else              d.cur_ch = CH_W'(bus_wdata[2:0]);
            end else if (q.busy && !bus_wdata[6]) begin
                d.busy     = 1'b0;
                core_abort = 1'b1;
            end
        end

        if (core_abort) begin
            store_en   = 1'b0;
            core_start = 1'b0;
            d.irq      = 1'b0;
            d.busy     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.ladder_off <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == CTRL0_ADDR)
            bus_rdata = {q.clk_half, q.busy, 1'b0, q.mode, q.chan};
        else if (bus_addr == CTRL1_ADDR)
            bus_rdata = {2'b00, q.ladder_off, 1'b0, q.ten_bit, 3'b000};
        else if (rd_hit)
            bus_rdata = bank_byte;
    end

    sar_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (core_start),
        .half_rate (q.clk_half),
        .tick      (tick)
    );

    sar_core #(.W(RES_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (core_start),
        .abort    (core_abort),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .done     (core_done),
        .result   (core_result)
    );

    sar_result_bank #(.NUM_CH(NUM_CH), .W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_ch   (store_ch),
        .wr_data (core_result),
        .ten_bit (q.ten_bit),
        .rd_ch   (rd_off[CH_W:1]),
        .rd_high (rd_off[0]),
        .rd_byte (bank_byte)
    );

    assign chan_sel  = 3'(q.cur_ch);
    assign ladder_en = !q.ladder_off;
    assign irq       = q.irq;
    assign busy_w    = q.busy;
    assign mode_w    = q.mode;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         ladder_en,
    input logic         busy,
    input logic [1:0]   mode,
    input logic [W-1:0] dac_code
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R12

    AST_BUSY_NEEDS_LADDER: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ladder_en); // R11

    AST_DAC_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == {1'b1, {(W-1){1'b0}}}); // R4

    AST_SINGLE_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode[0]) |-> !busy); // R7

    AST_REPEAT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mode != 2'b01); // R8

    AST_REP_SWEEP_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode == 2'b11) |-> busy); // R10
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(sar_adc_pkg::RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .ladder_en (ladder_en),
    .busy      (busy_w),
    .mode      (mode_w),
    .dac_code  (dac_code)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;
    logic       ladder_en, irq, cmp_in;
    logic [9:0] vin [8];

    int n_checks = 0;
    int n_err    = 0;
    int irq_cnt  = 0;
    bit finished = 1'b0;

    typedef struct { int ch; int val; bit ten; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    assign cmp_in = (vin[chan_sel] >= dac_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .chan_sel(chan_sel), .ladder_en(ladder_en), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] low_byte(input int val, input bit ten);
        return ten ? 8'(val & 'hFF) : 8'((val >> 2) & 'hFF);
    endfunction

    function automatic logic [7:0] high_byte(input int val, input bit ten);
        return ten ? 8'((val >> 8) & 'h3) : 8'h00;
    endfunction

    // Monitor: on each completion pulse compare every expected result
    initial begin
        logic [7:0] b;
        forever begin
            @(posedge clk);
            #2;
            if (irq) begin
                irq_cnt++;
                while (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q[0];
                    bus_read(8'(8'h20 + 2 * it.ch), b);
                    chk(it.ten ? "R5 low byte" : "R6 low byte", b, low_byte(it.val, it.ten));
                    bus_read(8'(8'h21 + 2 * it.ch), b);
                    chk(it.ten ? "R5 high byte" : "R6 high byte", b, high_byte(it.val, it.ten));
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic one_shot(input int ch, input int val, input bit ten, input bit half);
        int n;
        item_t it;
        vin[ch] = 10'(val);
        it.ch = ch; it.val = val; it.ten = ten;
        exp_q.push_back(it);
        bus_write(8'h1E, {half, 1'b1, 3'b000, 3'(ch)});
        chk("R4 first trial code", dac_code, 10'h200);
        n = 0;
        do begin
            @(posedge clk);
            #1 n++;
        end while (!irq);
        chk("R3 conversion latency", n, half ? 20 : 40);
        wait (exp_q.size() == 0);
        wait_cycles(2);
    endtask

    initial begin
        logic [7:0] b;
        int base;
        for (int i = 0; i < 8; i++) vin[i] = 10'h000;
        wait_cycles(3);
        #1 rst_n = 1'b1;
        wait_cycles(2);

        // R1 reset state
        bus_read(8'h1E, b); chk("R1 ctrl0 reset", b, 8'h00);
        bus_read(8'h1F, b); chk("R1 ctrl1 reset", b, 8'h20);
        bus_read(8'h20, b); chk("R1 result reset", b, 8'h00);
        bus_read(8'h2F, b); chk("R1 result reset", b, 8'h00);
        chk("R1 ladder_en reset", ladder_en, 0);
        chk("R1 irq reset", irq, 0);

        // R11 start ignored while ladder off
        bus_write(8'h1E, 8'h43);
        wait_cycles(1);
        bus_read(8'h1E, b); chk("R11 start while ladder off", b, 8'h03);
        bus_write(8'h1F, 8'h08);
        chk("R11 ladder_en follows bit 5", ladder_en, 1);
        bus_write(8'h1E, 8'h43);
        bus_read(8'h1E, b); chk("R11 start during settle", b, 8'h03);
        bus_read(8'h1F, b); chk("R2 ctrl1 readback", b, 8'h08);
        wait_cycles(20);

        // R7 one-shot, R5 10-bit, R3 both tick rates
        one_shot(3, 'h2A5, 1'b1, 1'b0);
        bus_read(8'h1E, b); chk("R7 busy cleared after one-shot", b, 8'h03);
        one_shot(3, 'h1C6, 1'b1, 1'b1);
        bus_read(8'h27, b); chk("R5 high byte bits 7:2 zero", b & 8'hFC, 8'h00);

        // R6 8-bit width
        bus_write(8'h1F, 8'h00);
        one_shot(5, 'h3FF, 1'b0, 1'b1);
        one_shot(5, 'h003, 1'b0, 1'b1);

        // R9 single sweep over eight distinct codes
        bus_write(8'h1F, 8'h08);
        for (int i = 0; i < 8; i++) begin
            item_t it;
            vin[i] = 10'((i * 'h85 + 'h31) & 'h3FF);
            it.ch = i; it.val = (i * 'h85 + 'h31) & 'h3FF; it.ten = 1'b1;
            exp_q.push_back(it);
        end
        base = irq_cnt;
        bus_write(8'h1E, 8'hD0);
        wait (exp_q.size() == 0);
        wait_cycles(200);
        chk("R9 one irq per single sweep", irq_cnt - base, 1);
        bus_read(8'h1E, b); chk("R9 busy cleared after sweep", b, 8'h90);

        // R8 repeat mode on channel 2
        base = irq_cnt;
        vin[2] = 10'h155;
        bus_write(8'h1E, 8'hCA);
        wait_cycles(60);
        bus_read(8'h24, b); chk("R8 repeat low byte", b, 8'h55);
        bus_read(8'h25, b); chk("R8 repeat high byte", b, 8'h01);
        vin[2] = 10'h0F0;
        wait_cycles(60);
        bus_read(8'h24, b); chk("R8 repeat refresh low", b, 8'hF0);
        bus_read(8'h25, b); chk("R8 repeat refresh high", b, 8'h00);
        bus_read(8'h1E, b); chk("R8 busy held", b, 8'hCA);
        chk("R8 no irq in repeat", irq_cnt - base, 0);

        // R13 stop by clearing bit 6
        bus_write(8'h1E, 8'h8A);
        wait_cycles(2);
        bus_read(8'h1E, b); chk("R13 busy cleared by stop", b, 8'h8A);
        vin[2] = 10'h3FF;
        wait_cycles(60);
        bus_read(8'h24, b); chk("R13 no store after stop", b, 8'hF0);

        // R10 repeat sweep
        base = irq_cnt;
        bus_write(8'h1E, 8'hD8);
        wait_cycles(400);
        chk("R10 irq per pass", (irq_cnt - base) >= 2, 1);
        bus_read(8'h1E, b); chk("R10 busy held", b, 8'hD8);
        bus_read(8'h24, b); chk("R10 sweep refresh ch2", b, 8'hFF);

        // R11 disconnect stops conversion
        bus_write(8'h1F, 8'h28);
        chk("R11 ladder_en low", ladder_en, 0);
        bus_read(8'h1E, b); chk("R11 disconnect clears busy", b, 8'h98);
        base = irq_cnt;
        wait_cycles(200);
        chk("R11 no irq after disconnect", irq_cnt - base, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule